// File: doc/BRIEF.md
# Event-Triggered Reload Timer

This block is an 8-bit down-counting timer for a contactless reader's protocol engine. A programmable power-of-two prescaler divides the system clock. Protocol events start and stop the timer: transmit-begin and transmit-end can start it, and receive-begin and receive-end can stop it. Each of these events has its own enable bit. Software start and stop strobes act as well. Every start reloads the counter from a reload register, even when the timer is already counting. This lets the block act as a retriggerable timeout or watchdog: a response that arrives in time stops the count with no interrupt.

When the count reaches zero, the block emits a one-cycle expiry pulse for an external interrupt register. It then either stops with the value at zero or reloads and keeps counting, which gives a periodic tick. Three small byte registers hold the configuration, and a write port selects among them. The current count and a running flag are visible at the ports. The exponent field saturates at 21, so the longest division is 2^21.

Top module: `evt_reload_timer`

## Requirements
- R1: After reset, value is 0, running is 0 and expire is 0. The registers hold their defaults: clock control 07h (exponent 7, no auto-restart), start/stop control 06h (start on transmit-end, stop on receive-begin) and reload 0Ah.
- R2: A start fires on a transmit-begin pulse when start/stop bit 0 is set, on a transmit-end pulse when bit 1 is set, or on the software start strobe. A disabled event has no effect.
- R3: A stop fires on a receive-begin pulse when start/stop bit 2 is set, on a receive-end pulse when bit 3 is set, or on the software stop strobe. On the next cycle running is 0, the value is unchanged and no expiry pulse is given. A disabled event has no effect.
- R4: Every start loads the reload value into the counter and sets running on the next cycle, even when the timer is already running.
- R5: While running, the value decrements once every 2^E cycles, where E is clock control bits [4:0]. The first decrement comes 2^E cycles after the start. The value holds when the timer is not running.
- R6: When a decrement would bring the value to zero, expire is high for that one cycle. If auto-restart is clear, running drops and the value reads 0.
- R7: If auto-restart (clock control bit 5) is set, the value is reloaded on expiry and counting continues, with the same period each time.
- R8: A start and a stop in the same cycle give a start.
- R9: Writes use wr_sel 0 for clock control, 1 for start/stop control and 2 for reload. A write takes effect on the next cycle, so a start in the same cycle as a reload write loads the old reload value.
- R10: With a reload value of 0, the timer expires on the first prescaled tick after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 clock control, 1 start/stop control, 2 reload |
| wr_data | input | 8 | Register write data |
| ev_tx_begin | input | 1 | Transmit-begin event pulse |
| ev_tx_end | input | 1 | Transmit-end event pulse |
| ev_rx_begin | input | 1 | Receive-begin event pulse |
| ev_rx_end | input | 1 | Receive-end event pulse |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| tmr_value | output | 8 | Current count |
| tmr_running | output | 1 | Timer is counting |
| tmr_expire | output | 1 | One-cycle expiry pulse |

## Verification
A wrong prescaler phase shows up at tmr_value one division period after a start, as a decrement in the wrong cycle. A wrong enable decode or priority shows up at tmr_running on the very next cycle. A stale reload register or a bad auto-restart path becomes visible at the first expiry: the pulse comes early or late, or the value after it is wrong. The bench compares every output on every cycle against its own model, so each error is reported in the cycle where it first appears.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CLK  = 2'd0,
    SEL_SS   = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CLK_RST = 8'h07;
  localparam logic [7:0] SS_RST  = 8'h06;
  localparam logic [7:0] RLD_RST = 8'h0A;

  localparam int unsigned SS_TXB = 0;
  localparam int unsigned SS_TXE = 1;
  localparam int unsigned SS_RXB = 2;
  localparam int unsigned SS_RXE = 3;
  localparam int unsigned CK_AUTO = 5;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned EXP_MAX = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ev_tx_begin,
  input  logic             ev_tx_end,
  input  logic             ev_rx_begin,
  input  logic             ev_rx_end,
  input  logic             sw_start,
  input  logic             sw_stop,
  output logic [CNT_W-1:0] reload,
  output logic [EXP_W-1:0] exp_sel,
  output logic             auto_rld,
  output logic             start_req,
  output logic             stop_req
);

  localparam int unsigned CK_W = EXP_W + 1;
  localparam int unsigned SS_W = 4;

  logic [CK_W-1:0]  ck_q, ck_d;
  logic [SS_W-1:0]  ss_q, ss_d;
  logic [CNT_W-1:0] rl_q, rl_d;
  logic             ck_en, ss_en, rl_en;

  always_comb begin
    ck_en = wr_en && (wr_sel == SEL_CLK);
    ss_en = wr_en && (wr_sel == SEL_SS);
    rl_en = wr_en && (wr_sel == SEL_RLD);
    ck_d  = wr_data[CK_W-1:0];
    ss_d  = wr_data[SS_W-1:0];
    rl_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= CLK_RST[CK_W-1:0];
      ss_q <= SS_RST[SS_W-1:0];
      rl_q <= CNT_W'(RLD_RST);
    end else begin
      if (ck_en) ck_q <= ck_d;
      if (ss_en) ss_q <= ss_d;
      if (rl_en) rl_q <= rl_d;
    end
  end

  always_comb begin
    start_req = (ev_tx_begin && ss_q[SS_TXB]) ||
                (ev_tx_end   && ss_q[SS_TXE]) || sw_start;
    stop_req  = (ev_rx_begin && ss_q[SS_RXB]) ||
                (ev_rx_end   && ss_q[SS_RXE]) || sw_stop;
    if (ck_q[EXP_W-1:0] > EXP_W'(EXP_MAX)) exp_sel = EXP_W'(EXP_MAX);
    else                                   exp_sel = ck_q[EXP_W-1:0];
    auto_rld = ck_q[CK_AUTO];
    reload   = rl_q;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned EXP_MAX = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);

  localparam int unsigned PRE_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [PRE_W-1:0] cnt_q, cnt_d, mask;
  logic             cnt_en;

  always_comb begin
    mask   = (PRE_W'(1) << exp_sel) - PRE_W'(1);
    tick   = run && ((cnt_q & mask) == mask);
    cnt_en = clear || run;
    cnt_d  = clear ? '0 : cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic             auto_rld,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] value,
  output logic             running,
  output logic             expire
);

  logic [CNT_W-1:0] val_q, val_d;
  logic             run_q, run_d, xp_q, xp_d, last;

  always_comb begin
    val_d = val_q;
    run_d = run_q;
    xp_d  = 1'b0;
    last  = (val_q <= CNT_W'(1));
    if (start) begin
      val_d = reload;
      run_d = 1'b1;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (last) begin
        xp_d  = 1'b1;
        val_d = auto_rld ? reload : '0;
        run_d = auto_rld;
      end else begin
        val_d = val_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      run_q <= 1'b0;
      xp_q  <= 1'b0;
    end else begin
      val_q <= val_d;
      run_q <= run_d;
      xp_q  <= xp_d;
    end
  end

  assign value   = val_q;
  assign running = run_q;
  assign expire  = xp_q;

  assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && value == $past(reload)));

  assert_stop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!running && !expire && $stable(value)));

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> ($stable(value) && !expire));

  assert_expire_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(running));

  assert_expire_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !running) |-> (value == '0));

  assert_auto_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !start && !stop && value <= CNT_W'(1) && auto_rld)
      |=> (running && expire && value == $past(reload)));

  assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stop) |=> running);

endmodule

// File: rtl/evt_reload_timer.sv
module evt_reload_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned EXP_W   = 5,
  parameter int unsigned EXP_MAX = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ev_tx_begin,
  input  logic             ev_tx_end,
  input  logic             ev_rx_begin,
  input  logic             ev_rx_end,
  input  logic             sw_start,
  input  logic             sw_stop,
  output logic [CNT_W-1:0] tmr_value,
  output logic             tmr_running,
  output logic             tmr_expire
);

  logic [CNT_W-1:0] reload;
  logic [EXP_W-1:0] exp_sel;
  logic             auto_rld, start_req, stop_req, tick;

  tmr_regs #(.CNT_W(CNT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_tx_begin(ev_tx_begin), .ev_tx_end(ev_tx_end),
    .ev_rx_begin(ev_rx_begin), .ev_rx_end(ev_rx_end),
    .sw_start(sw_start), .sw_stop(sw_stop),
    .reload(reload), .exp_sel(exp_sel), .auto_rld(auto_rld),
    .start_req(start_req), .stop_req(stop_req)
  );

  tmr_prescaler #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) pre_i (
    .clk(clk), .rst_n(rst_n), .clear(start_req), .run(tmr_running),
    .exp_sel(exp_sel), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .start(start_req), .stop(stop_req), .tick(tick),
    .auto_rld(auto_rld), .reload(reload),
    .value(tmr_value), .running(tmr_running), .expire(tmr_expire)
  );

endmodule

// File: tb/evt_reload_timer_tb_top.sv
module evt_reload_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       ev_tx_begin, ev_tx_end, ev_rx_begin, ev_rx_end;
  logic       sw_start, sw_stop;
  logic [7:0] tmr_value;
  logic       tmr_running, tmr_expire;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  logic [7:0] m_ck, m_ss, m_rl, m_val;
  logic       m_run, m_xp;
  int         m_ph;

  always #4 clk = ~clk;

  evt_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_tx_begin(ev_tx_begin), .ev_tx_end(ev_tx_end),
    .ev_rx_begin(ev_rx_begin), .ev_rx_end(ev_rx_end),
    .sw_start(sw_start), .sw_stop(sw_stop),
    .tmr_value(tmr_value), .tmr_running(tmr_running), .tmr_expire(tmr_expire)
  );

  function automatic int period_of(input logic [7:0] ck);
    int e;
    e = int'(ck[4:0]);
    if (e > 21) e = 21;
    return 1 << e;
  endfunction

  task automatic model_step();
    logic st, sp;
    st = (ev_tx_begin && m_ss[0]) || (ev_tx_end && m_ss[1]) || sw_start;
    sp = (ev_rx_begin && m_ss[2]) || (ev_rx_end && m_ss[3]) || sw_stop;
    m_xp = 1'b0;
    if (st) begin
      m_val = m_rl; m_run = 1'b1; m_ph = 0;
    end else if (sp) begin
      m_run = 1'b0;
    end else if (m_run) begin
      if (m_ph == period_of(m_ck) - 1) begin
        m_ph = 0;
        if (m_val <= 8'd1) begin
          m_xp = 1'b1;
          if (m_ck[5]) m_val = m_rl;
          else begin m_val = 8'd0; m_run = 1'b0; end
        end else m_val = m_val - 8'd1;
      end else m_ph = m_ph + 1;
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_ck = {2'b00, wr_data[5:0]};
        2'd1: m_ss = {4'h0, wr_data[3:0]};
        2'd2: m_rl = wr_data;
        default: ;
      endcase
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (tmr_value !== m_val || tmr_running !== m_run || tmr_expire !== m_xp) begin
      miscompares++;
      $display("FAIL %s: value=%0h running=%0b expire=%0b, expected value=%0h running=%0b expire=%0b",
               tag, tmr_value, tmr_running, tmr_expire, m_val, m_run, m_xp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00;
    ev_tx_begin = 1'b0; ev_tx_end = 1'b0; ev_rx_begin = 1'b0; ev_rx_end = 1'b0;
    sw_start = 1'b0; sw_stop = 1'b0;
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    clear_inputs();
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cycle("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    m_ck = 8'h07; m_ss = 8'h06; m_rl = 8'h0A; m_val = 8'h00;
    m_run = 1'b0; m_xp = 1'b0; m_ph = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    ev_tx_begin = 1'b1; cycle("R2");
    ev_rx_end = 1'b1;   cycle("R3");
    ev_tx_end = 1'b1;   cycle("R1");
    idle(300, "R5");
    ev_rx_end = 1'b1;   cycle("R3");
    ev_rx_begin = 1'b1; cycle("R3");
    idle(20, "R3");

    wr(2'd0, 8'h00);
    wr(2'd2, 8'h03);
    sw_start = 1'b1; cycle("R2");
    idle(6, "R6");

    wr(2'd0, 8'h21);
    wr(2'd2, 8'h02);
    sw_start = 1'b1; cycle("R7");
    idle(11, "R7");
    sw_start = 1'b1; cycle("R4");
    idle(3, "R4");
    sw_stop = 1'b1; cycle("R3");
    sw_start = 1'b1; sw_stop = 1'b1; cycle("R8");
    idle(4, "R8");

    sw_stop = 1'b1; cycle("R3");
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h00);
    sw_start = 1'b1; cycle("R10");
    idle(6, "R10");

    wr(2'd1, 8'h0F);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h05; sw_start = 1'b1; cycle("R9");
    idle(4, "R9");
    ev_tx_begin = 1'b1; cycle("R2");
    ev_rx_end = 1'b1; cycle("R3");

    for (int i = 0; i < 5000; i++) begin
      string tag;
      tag = "R5";
      if ($urandom % 10 == 0) begin
        logic [1:0] s;
        s = 2'($urandom % 3);
        if (s == 2'd0 && m_run) s = 2'd2;
        wr_en = 1'b1; wr_sel = s;
        case (s)
          2'd0: wr_data = {2'b00, 1'($urandom), 5'($urandom % 4)};
          2'd1: wr_data = {4'h0, 4'($urandom)};
          default: wr_data = 8'($urandom % 6);
        endcase
        tag = "R9";
      end
      ev_rx_begin = ($urandom % 24 == 0);
      ev_rx_end   = ($urandom % 24 == 0);
      sw_stop     = ($urandom % 40 == 0);
      if (ev_rx_begin || ev_rx_end || sw_stop) tag = "R3";
      ev_tx_begin = ($urandom % 20 == 0);
      ev_tx_end   = ($urandom % 20 == 0);
      sw_start    = ($urandom % 30 == 0);
      if (ev_tx_begin || ev_tx_end || sw_start) tag = "R2";
      if (m_run && m_val <= 8'd1) tag = "R6";
      cycle(tag);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule